// File: doc/BRIEF.md
# 64-bit Shift and Rotate Unit

A purely combinational shifter for the execute stage of a 64-bit integer pipeline. It performs logical left shift, logical right shift, arithmetic right shift and rotate right on a 64-bit operand, producing the 64-bit result in the same cycle the inputs are presented.

Two amount sources are supported. In the immediate form, the amount is a 5-bit field; a separate flag adds 32 to it, which reaches amounts 32 to 63. The operand shifted in this form is the first operand. In the variable form, the amount is the low six bits of the first operand, and the value shifted is the second operand. All four operations go through one logarithmic stage chain, so each operation costs the same logic depth.

Top module: `shf_unit64`

## Requirements
- R1: Operation code 0 (shift left logical) returns the data shifted left by the effective amount, with zeros entering at bit 0.
- R2: Operation code 1 (shift right logical) returns the data shifted right by the effective amount, with zeros entering at bit 63.
- R3: Operation code 2 (shift right arithmetic) returns the data shifted right by the effective amount, with copies of the data's bit 63 entering the vacated upper bits.
- R4: Operation code 3 (rotate right) returns (d >> n) | (d << (64 - n)) for a nonzero effective amount n, and returns the data unchanged when n is zero.
- R5: With `amt_var` = 0, the effective amount is `imm_amt` (0 to 31), plus 32 when `amt_plus32` = 1.
- R6: With `amt_var` = 1, the effective amount is `opnd_a[5:0]`; bits 63:6 of `opnd_a` have no effect on the result.
- R7: With `amt_var` = 0 the shifted data is `opnd_a`; with `amt_var` = 1 it is `opnd_b`.
- R8: With `amt_var` = 1, `amt_plus32` and `imm_amt` have no effect on the result.
- R9: Operation codes 4 to 7 produce a result of zero.
- R10: The result follows the inputs combinationally, with no clock edge between a change of input and the matching result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 3 | Operation: 0 left logical, 1 right logical, 2 right arithmetic, 3 rotate right, 4-7 unused |
| amt_var | input | 1 | 1 selects the variable form (amount from `opnd_a[5:0]`, data from `opnd_b`) |
| amt_plus32 | input | 1 | In the immediate form, adds 32 to the amount |
| imm_amt | input | 5 | Immediate shift amount |
| opnd_a | input | 64 | First operand: data in immediate form, amount in variable form |
| opnd_b | input | 64 | Second operand: data in variable form |
| result | output | 64 | Shift or rotate result |

## Verification
Every result is due zero cycles after its stimulus: the block holds no state, so the result settles within the same cycle. The bench changes inputs at the falling clock edge and samples one nanosecond later, well before the next rising edge, and one scenario changes inputs several times between edges to show no edge is needed. Expected values come from a reference function written from the requirement text, covering amounts 0, 1, 31, 32, 63, masked upper amount bits and the unused codes.

// File: rtl/shf_pkg.sv
// Package: shared operation codes and width helpers for the shift unit.
// Assumes the operation code is three bits wide; codes above OP_ROTR are unused.
package shf_pkg;
    localparam int OPW = 3;
    localparam logic [OPW-1:0] OP_SLL  = 3'd0;
    localparam logic [OPW-1:0] OP_SRL  = 3'd1;
    localparam logic [OPW-1:0] OP_SRA  = 3'd2;
    localparam logic [OPW-1:0] OP_ROTR = 3'd3;
    localparam logic [OPW-1:0] OP_LAST = OP_ROTR;
endpackage

// File: rtl/shf_amount.sv
// Module: shf_amount
// Picks the effective amount and the data to shift from the two operand
// forms. Assumes W is a power of two; the immediate field is one bit
// narrower than the full amount, and the plus-32 flag supplies its top bit.
module shf_amount #(
    parameter int W  = 64,
    parameter int AW = $clog2(W),
    parameter int IW = AW - 1
) (
    input  logic          amt_var,
    input  logic          amt_plus32,
    input  logic [IW-1:0] imm_amt,
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  opnd_b,
    output logic [AW-1:0] eff_amt,
    output logic [W-1:0]  eff_data
);
    // Amount and data selection between immediate and variable forms.
    always_comb begin
        if (amt_var) begin
            eff_amt  = opnd_a[AW-1:0];
            eff_data = opnd_b;
        end else begin
            eff_amt  = {amt_plus32, imm_amt};
            eff_data = opnd_a;
        end
    end
endmodule

// File: rtl/shf_stage.sv
// Module: shf_stage
// One stage of the logarithmic shifter: moves the word by a fixed distance
// D when enabled, in the direction and with the fill the operation asks for.
// Assumes 0 < D < W. Unused operation codes pass the word through; the top
// level forces them to zero.
module shf_stage
    import shf_pkg::*;
#(
    parameter int W = 64,
    parameter int D = 1
) (
    input  logic [OPW-1:0] op,
    input  logic           en,
    input  logic           fill,
    input  logic [W-1:0]   din,
    output logic [W-1:0]   dout
);
    // Per-operation move by D positions, or pass-through when disabled.
    always_comb begin
        dout = din;
        if (en) begin
            case (op)
                OP_SLL:  dout = {din[W-1-D:0], {D{1'b0}}};
                OP_SRL:  dout = {{D{1'b0}}, din[W-1:D]};
                OP_SRA:  dout = {{D{fill}}, din[W-1:D]};
                OP_ROTR: dout = {din[D-1:0], din[W-1:D]};
                default: dout = din;
            endcase
        end
    end
endmodule

// File: rtl/shf_unit64.sv
// Module: shf_unit64 (top)
// Combinational shift and rotate unit. The amount selector feeds a chain of
// log2(W) stages, stage k moving by 2**k; the final word is zeroed for
// unused operation codes. Assumes W is a power of two of at least 4.
module shf_unit64
    import shf_pkg::*;
#(
    parameter int W  = 64,
    parameter int AW = $clog2(W),
    parameter int IW = AW - 1
) (
    input  logic [OPW-1:0] op_code,
    input  logic           amt_var,
    input  logic           amt_plus32,
    input  logic [IW-1:0]  imm_amt,
    input  logic [W-1:0]   opnd_a,
    input  logic [W-1:0]   opnd_b,
    output logic [W-1:0]   result
);
    logic [AW-1:0] eff_amt;
    logic [W-1:0]  eff_data;
    logic [W-1:0]  chain [0:AW];
    logic          sign_bit;

    shf_amount #(.W(W), .AW(AW), .IW(IW)) u_amt (
        .amt_var   (amt_var),
        .amt_plus32(amt_plus32),
        .imm_amt   (imm_amt),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .eff_amt   (eff_amt),
        .eff_data  (eff_data)
    );

    // Sign of the original data, used as arithmetic fill in every stage.
    assign sign_bit = eff_data[W-1];
    assign chain[0] = eff_data;

    // Stage k shifts by 2**k when amount bit k is set.
    for (genvar k = 0; k < AW; k++) begin : g_stage
        shf_stage #(.W(W), .D(1 << k)) u_stage (
            .op  (op_code),
            .en  (eff_amt[k]),
            .fill(sign_bit),
            .din (chain[k]),
            .dout(chain[k+1])
        );
    end

    // Output gating: unused operation codes give zero.
    always_comb begin
        result = (op_code > OP_LAST) ? '0 : chain[AW];
    end
endmodule

// File: rtl/shf_unit64_chk.sv
// Module: shf_unit64_chk
// Checker for shf_unit64, attached by bind. Works from the ports only and
// rebuilds the effective amount and data from the requirement text.
// Immediate assertions, since the block holds no state.
module shf_unit64_chk
    import shf_pkg::*;
#(
    parameter int W  = 64,
    parameter int AW = $clog2(W),
    parameter int IW = AW - 1
) (
    input logic [OPW-1:0] op_code,
    input logic           amt_var,
    input logic           amt_plus32,
    input logic [IW-1:0]  imm_amt,
    input logic [W-1:0]   opnd_a,
    input logic [W-1:0]   opnd_b,
    input logic [W-1:0]   result
);
    logic [AW-1:0] c_amt;
    logic [W-1:0]  c_data;

    // Independent view of amount and data per R5, R6, R7.
    always_comb begin
        c_amt  = amt_var ? opnd_a[AW-1:0] : {amt_plus32, imm_amt};
        c_data = amt_var ? opnd_b : opnd_a;
    end

    // Property checks on settled combinational outputs.
    always_comb begin
        if (op_code == OP_SLL && c_amt != '0)
            assert_sll_zero_fill_R1: assert (result[0] == 1'b0);
        if (op_code == OP_SRL && c_amt != '0)
            assert_srl_zero_fill_R2: assert (result[W-1] == 1'b0);
        if (op_code == OP_SRA)
            assert_sra_sign_kept_R3: assert (result[W-1] == c_data[W-1]);
        if (op_code == OP_ROTR && c_amt == '0)
            assert_rot_zero_pass_R4: assert (result == c_data);
        if (op_code == OP_ROTR)
            assert_rot_ones_kept_R4: assert ($countones(result) == $countones(c_data));
        if (op_code > OP_LAST)
            assert_unused_zero_R9: assert (result == '0);
    end
endmodule

bind shf_unit64 shf_unit64_chk #(.W(W), .AW(AW), .IW(IW)) u_chk (
    .op_code   (op_code),
    .amt_var   (amt_var),
    .amt_plus32(amt_plus32),
    .imm_amt   (imm_amt),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .result    (result)
);

// File: tb/sim_shf_unit64.sv
// Bench for shf_unit64: directed scenarios, one task each, against a
// reference function written from the requirements.
`timescale 1ns/1ps
module sim_shf_unit64;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic        amt_var = 1'b0;
    logic        amt_plus32 = 1'b0;
    logic [4:0]  imm_amt = 5'd0;
    logic [63:0] opnd_a = 64'd0;
    logic [63:0] opnd_b = 64'd0;
    logic [63:0] result;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    shf_unit64 u0 (
        .op_code(op_code), .amt_var(amt_var), .amt_plus32(amt_plus32),
        .imm_amt(imm_amt), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result)
    );

    function automatic logic [63:0] ref_res(input logic [2:0] op, input logic v,
            input logic p, input logic [4:0] im, input logic [63:0] a, input logic [63:0] b);
        int n;
        logic [63:0] d;
        n = v ? int'(a[5:0]) : (p ? 32 : 0) + int'(im);
        d = v ? b : a;
        case (op)
            3'd0: return d << n;
            3'd1: return d >> n;
            3'd2: return 64'($signed(d) >>> n);
            3'd3: return (n == 0) ? d : ((d >> n) | (d << (64 - n)));
            default: return 64'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] exp);
        n_chk++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, result, exp);
        end
    endtask

    // Drive at the falling edge, sample 1 ns later (result due same cycle).
    task automatic apply(input string tag, input logic [2:0] op, input logic v, input logic p,
            input logic [4:0] im, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        op_code = op; amt_var = v; amt_plus32 = p; imm_amt = im; opnd_a = a; opnd_b = b;
        #1;
        check(tag, ref_res(op, v, p, im, a, b));
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        #1;
        check("R1 idle inputs", 64'd0);
    endtask

    task automatic t_sll();
        apply("R1 sll 1", 3'd0, 1'b0, 1'b0, 5'd1, 64'h8000_0000_0000_0001, 64'd0);
        apply("R1 sll 31", 3'd0, 1'b0, 1'b0, 5'd31, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
        apply("R1 sll 0", 3'd0, 1'b0, 1'b0, 5'd0, 64'h1234_5678_9ABC_DEF0, 64'd0);
    endtask

    task automatic t_srl();
        apply("R2 srl 4", 3'd1, 1'b0, 1'b0, 5'd4, 64'hF000_0000_0000_000F, 64'd0);
        apply("R2 srl 63", 3'd1, 1'b0, 1'b1, 5'd31, 64'h8000_0000_0000_0000, 64'd0);
    endtask

    task automatic t_sra();
        apply("R3 sra neg 8", 3'd2, 1'b0, 1'b0, 5'd8, 64'h8123_4567_89AB_CDEF, 64'd0);
        apply("R3 sra neg 63", 3'd2, 1'b0, 1'b1, 5'd31, 64'h8000_0000_0000_0000, 64'd0);
        apply("R3 sra pos 5", 3'd2, 1'b0, 1'b0, 5'd5, 64'h7FFF_0000_FFFF_0000, 64'd0);
        check("R3 sra pos explicit", 64'h03FF_F800_07FF_F800);
    endtask

    task automatic t_rotr();
        apply("R4 rotr 1", 3'd3, 1'b0, 1'b0, 5'd1, 64'h0000_0000_0000_0001, 64'd0);
        check("R4 rotr 1 explicit", 64'h8000_0000_0000_0000);
        apply("R4 rotr 0", 3'd3, 1'b0, 1'b0, 5'd0, 64'hDEAD_BEEF_0123_4567, 64'd0);
        check("R4 rotr 0 passthrough", 64'hDEAD_BEEF_0123_4567);
        apply("R4 rotr 36", 3'd3, 1'b0, 1'b1, 5'd4, 64'h0123_4567_89AB_CDEF, 64'd0);
    endtask

    task automatic t_plus32();
        apply("R5 sll 32", 3'd0, 1'b0, 1'b1, 5'd0, 64'h0000_0000_CAFE_F00D, 64'd0);
        check("R5 sll 32 explicit", 64'hCAFE_F00D_0000_0000);
        apply("R5 srl 33", 3'd1, 1'b0, 1'b1, 5'd1, 64'hFFFF_FFFF_0000_0000, 64'd0);
        check("R5 srl 33 explicit", 64'h0000_0000_7FFF_FFFF);
    endtask

    task automatic t_var_mask();
        apply("R6 var sll masked", 3'd0, 1'b1, 1'b0, 5'd0, 64'hFFFF_FFFF_FFFF_FFC3, 64'h1);
        check("R6 var sll 3 explicit", 64'h8);
        apply("R6 var srl 63", 3'd1, 1'b1, 1'b0, 5'd0, 64'h0000_0000_0000_007F, 64'h8000_0000_0000_0000);
        check("R6 var srl 63 explicit", 64'h1);
    endtask

    task automatic t_var_operand();
        apply("R7 var data from b", 3'd3, 1'b1, 1'b0, 5'd0, 64'h40, 64'hA5A5_0000_0000_5A5A);
        check("R7 var rotr 0 gives b", 64'hA5A5_0000_0000_5A5A);
        apply("R7 imm data from a", 3'd0, 1'b0, 1'b0, 5'd4, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R7 imm uses a", 64'h10);
    endtask

    task automatic t_var_ignores_imm();
        apply("R8 var plus32 ignored", 3'd0, 1'b1, 1'b1, 5'd17, 64'h2, 64'h1);
        check("R8 var sll 2 explicit", 64'h4);
    endtask

    task automatic t_unused();
        for (int c = 4; c < 8; c++) begin
            apply("R9 unused code", 3'(c), 1'b0, 1'b0, 5'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
            check("R9 unused zero", 64'd0);
        end
    endtask

    task automatic t_same_cycle();
        @(posedge clk);
        #0.5;
        op_code = 3'd1; amt_var = 1'b0; amt_plus32 = 1'b0; imm_amt = 5'd16; opnd_a = 64'hFFFF_0000_0000_0000;
        #0.5;
        check("R10 no edge 1", 64'h0000_FFFF_0000_0000);
        op_code = 3'd0;
        #0.5;
        check("R10 no edge 2", 64'h0000_0000_0000_0000);
        opnd_a = 64'h0000_0000_0000_FFFF;
        #0.5;
        check("R10 no edge 3", 64'h0000_0000_FFFF_0000);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_sll();
        t_srl();
        t_sra();
        t_rotr();
        t_plus32();
        t_var_mask();
        t_var_operand();
        t_var_ignores_imm();
        t_unused();
        t_same_cycle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule